// File: doc/BRIEF.md
# I/O Translation Unit Register Block

This block holds the software-visible configuration and fault-reporting state of an I/O address translation unit. A host bus reaches it through a word-addressed port with separate read and write strobes. Every named register applies its own write mask and may force certain bits to fixed values. All other word offsets inside the decoded span behave as plain 32-bit storage.

The 3-bit window-size field of the control register is decoded into the lowest address of the translated DMA window at the top of the 32-bit space. That start address is driven on an output for the translation datapath. The translation unit reports faults through a side port. A one-cycle strobe on that port overwrites the fault status and fault address registers together, and the strobe wins over a bus write to either register in the same cycle.

Top module: `iommu_regs`

## Requirements
- R1: After reset, control reads `{VersionId, 24'h0}`, arbitration reads 0x00000008, fault status reads 0x00800000, and every other register, every plain word and `windowStart` read 0.
- R2: A write to control (word 0x000) keeps only bits 0, 2, 3 and 4 of the data (mask 0x0000001D) and forces bits 31:24 to `VersionId`.
- R3: A control write with window code c = data[4:2] sets `windowStart` to 0xFF000000 shifted left by c, giving 0xFF000000 for c=0 and 0x80000000 for c=7. The new value appears one cycle after the write, and `windowStart` changes at no other time.
- R4: Page-table base (word 0x001) keeps mask 0x07FFFC00. Full-flush (word 0x005) and page-flush (word 0x006) keep all 32 bits.
- R5: A bus write to fault status (word 0x400) keeps mask 0xFF0FFFFF and forces bit 23 to 1. Fault address (word 0x401) keeps all 32 bits.
- R6: The four slot configuration registers (words 0x404 to 0x407) each keep mask 0x00010003 and are independent of one another.
- R7: A write to the arbitration register (word 0x800) keeps mask 0x001F0000 and forces bit 3 to 1.
- R8: Any other word offset below 3072 stores and returns the full 32-bit value last written to it.
- R9: Word offsets from 3072 upward read 0, and writes to them have no effect.
- R10: When `faultLoad` is high, fault status takes `(faultStatus & 0xFF0FFFFF) | 0x00800000` and fault address takes `faultAddr`. This overrides a bus write to either register in the same cycle.
- R11: `busRdata` shows the addressed register one cycle after `busRdEn`. It holds its value while no read is made, and reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 12 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| faultLoad | input | 1 | Fault record load strobe from the translation unit |
| faultStatus | input | 32 | Fault status to load |
| faultAddr | input | 32 | Faulting address to load |
| windowStart | output | 32 | Decoded start of the translated window |

## Verification
Read data is due one cycle after the read strobe. The monitor therefore compares `busRdata` at the falling edge that follows the rising edge on which the strobe was sampled, and pops expectations in issue order. `windowStart` is due one cycle after the control write, so the driver samples it on the next falling edge. A fault load and a conflicting bus write are issued in the same cycle, and both registers are read afterwards to confirm that the fault record won.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;
  localparam int DataW     = 32;
  localparam int AddrW     = 12;
  localparam int SpanWords = 3072;
  localparam int NumSlots  = 4;
  localparam int SlotIdxW  = $clog2(NumSlots);

  localparam logic [AddrW-1:0] OffCtrl      = 12'h000;
  localparam logic [AddrW-1:0] OffBase      = 12'h001;
  localparam logic [AddrW-1:0] OffFlushAll  = 12'h005;
  localparam logic [AddrW-1:0] OffFlushPage = 12'h006;
  localparam logic [AddrW-1:0] OffFltStat   = 12'h400;
  localparam logic [AddrW-1:0] OffFltAddr   = 12'h401;
  localparam logic [AddrW-1:0] OffSlot0     = 12'h404;
  localparam logic [AddrW-1:0] OffArb       = 12'h800;

  localparam logic [DataW-1:0] MaskCtrl    = 32'h0000_001D;
  localparam logic [DataW-1:0] MaskBase    = 32'h07FF_FC00;
  localparam logic [DataW-1:0] MaskFltStat = 32'hFF0F_FFFF;
  localparam logic [DataW-1:0] ForceStat   = 32'h0080_0000;
  localparam logic [DataW-1:0] MaskSlot    = 32'h0001_0003;
  localparam logic [DataW-1:0] MaskArb     = 32'h001F_0000;
  localparam logic [DataW-1:0] ForceArb    = 32'h0000_0008;
  localparam logic [DataW-1:0] TopWindow   = 32'hFF00_0000;

  typedef enum logic [3:0] {
    SelCtrl, SelBase, SelFlushAll, SelFlushPage, SelFltStat,
    SelFltAddr, SelSlot, SelArb, SelPlain, SelNone
  } rdSel_e;

  typedef struct packed {
    logic                wrCtrl;
    logic                wrBase;
    logic                wrFlushAll;
    logic                wrFlushPage;
    logic                wrFltStat;
    logic                wrFltAddr;
    logic [NumSlots-1:0] wrSlot;
    logic                wrArb;
    logic                wrPlain;
    logic                ldFault;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [SlotIdxW-1:0] slotIdx;
  } regStrobes_t;
endpackage

// File: rtl/iommu_reg_decode.sv
module iommu_reg_decode
  import iommu_regs_pkg::*;
(
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [AddrW-1:0] busAddr,
  input  logic             faultLoad,
  output regStrobes_t      strobes
);
  rdSel_e              sel;
  logic [NumSlots-1:0] slotHit;
  logic [SlotIdxW-1:0] slotIdx;

  for (genvar s = 0; s < NumSlots; s++) begin : g_slot
    assign slotHit[s] = (busAddr == OffSlot0 + AddrW'(s));
  end

  always_comb begin
    slotIdx = '0;
    for (int s = 0; s < NumSlots; s++) begin
      if (slotHit[s]) slotIdx = SlotIdxW'(s);
    end
  end

  always_comb begin
    if (busAddr == OffCtrl)                 sel = SelCtrl;
    else if (busAddr == OffBase)            sel = SelBase;
    else if (busAddr == OffFlushAll)        sel = SelFlushAll;
    else if (busAddr == OffFlushPage)       sel = SelFlushPage;
    else if (busAddr == OffFltStat)         sel = SelFltStat;
    else if (busAddr == OffFltAddr)         sel = SelFltAddr;
    else if (|slotHit)                      sel = SelSlot;
    else if (busAddr == OffArb)             sel = SelArb;
    else if (int'(busAddr) < SpanWords)     sel = SelPlain;
    else                                    sel = SelNone;
  end

  always_comb begin
    strobes             = '0;
    strobes.wrCtrl      = busWrEn && sel == SelCtrl;
    strobes.wrBase      = busWrEn && sel == SelBase;
    strobes.wrFlushAll  = busWrEn && sel == SelFlushAll;
    strobes.wrFlushPage = busWrEn && sel == SelFlushPage;
    strobes.wrFltStat   = busWrEn && sel == SelFltStat && !faultLoad;
    strobes.wrFltAddr   = busWrEn && sel == SelFltAddr && !faultLoad;
    strobes.wrSlot      = busWrEn ? slotHit : '0;
    strobes.wrArb       = busWrEn && sel == SelArb;
    strobes.wrPlain     = busWrEn && sel == SelPlain;
    strobes.ldFault     = faultLoad;
    strobes.rdEn        = busRdEn;
    strobes.rdSel       = sel;
    strobes.slotIdx     = slotIdx;
  end
endmodule

// File: rtl/iommu_reg_file.sv
module iommu_reg_file
  import iommu_regs_pkg::*;
#(
  parameter logic [7:0] VersionId = 8'h41
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strobes,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  input  logic [DataW-1:0] faultStatus,
  input  logic [DataW-1:0] faultAddr,
  output logic [DataW-1:0] busRdata,
  output logic [DataW-1:0] windowStart
);
  localparam logic [DataW-1:0] VersionBits = {VersionId, {(DataW-8){1'b0}}};

  logic [DataW-1:0] ctrlReg, baseReg, flushAllReg, flushPageReg;
  logic [DataW-1:0] fltStatReg, fltAddrReg, arbReg;
  logic [DataW-1:0] slotReg [NumSlots];
  logic [DataW-1:0] plainMem [SpanWords];
  logic [DataW-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg      <= VersionBits;
      baseReg      <= '0;
      flushAllReg  <= '0;
      flushPageReg <= '0;
      fltStatReg   <= ForceStat;
      fltAddrReg   <= '0;
      arbReg       <= ForceArb;
      windowStart  <= '0;
    end else begin
      if (strobes.wrCtrl) begin
        ctrlReg     <= (busWdata & MaskCtrl) | VersionBits;
        windowStart <= TopWindow << busWdata[4:2];
      end
      if (strobes.wrBase)      baseReg      <= busWdata & MaskBase;
      if (strobes.wrFlushAll)  flushAllReg  <= busWdata;
      if (strobes.wrFlushPage) flushPageReg <= busWdata;
      if (strobes.ldFault) begin
        fltStatReg <= (faultStatus & MaskFltStat) | ForceStat;
        fltAddrReg <= faultAddr;
      end else begin
        if (strobes.wrFltStat) fltStatReg <= (busWdata & MaskFltStat) | ForceStat;
        if (strobes.wrFltAddr) fltAddrReg <= busWdata;
      end
      if (strobes.wrArb) arbReg <= (busWdata & MaskArb) | ForceArb;
    end
  end

  for (genvar s = 0; s < NumSlots; s++) begin : g_slotReg
    always_ff @(posedge clk) begin
      if (!rstN)                   slotReg[s] <= '0;
      else if (strobes.wrSlot[s])  slotReg[s] <= busWdata & MaskSlot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SpanWords; i++) plainMem[i] <= '0;
    end else if (strobes.wrPlain) begin
      plainMem[busAddr] <= busWdata;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SelCtrl:      rdMux = ctrlReg;
      SelBase:      rdMux = baseReg;
      SelFlushAll:  rdMux = flushAllReg;
      SelFlushPage: rdMux = flushPageReg;
      SelFltStat:   rdMux = fltStatReg;
      SelFltAddr:   rdMux = fltAddrReg;
      SelSlot:      rdMux = slotReg[strobes.slotIdx];
      SelArb:       rdMux = arbReg;
      SelPlain:     rdMux = plainMem[busAddr];
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdata <= '0;
    else if (strobes.rdEn) busRdata <= rdMux;
  end
endmodule

// File: rtl/iommu_regs.sv
module iommu_regs
  import iommu_regs_pkg::*;
#(
  parameter logic [7:0] VersionId = 8'h41
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  input  logic             faultLoad,
  input  logic [DataW-1:0] faultStatus,
  input  logic [DataW-1:0] faultAddr,
  output logic [DataW-1:0] windowStart
);
  regStrobes_t strobes;

  iommu_reg_decode u_decode (
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .faultLoad(faultLoad),
    .strobes  (strobes)
  );

  iommu_reg_file #(.VersionId(VersionId)) u_file (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .faultStatus(faultStatus),
    .faultAddr  (faultAddr),
    .busRdata   (busRdata),
    .windowStart(windowStart)
  );
endmodule

// File: rtl/iommu_regs_checker.sv
module iommu_regs_checker
  import iommu_regs_pkg::*;
#(
  parameter logic [7:0] VersionId = 8'h41
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [AddrW-1:0] busAddr,
  input logic [DataW-1:0] busRdata,
  input logic             faultLoad,
  input logic [DataW-1:0] faultAddr,
  input logic [DataW-1:0] windowStart
);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdata));

  p_window_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == OffCtrl) |=> $stable(windowStart));

  p_window_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    windowStart[23:0] == '0 && (windowStart == '0 || windowStart[31]));

  p_version_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == OffCtrl |=> busRdata[31:24] == VersionId);

  p_arb_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == OffArb |=> busRdata[3]);

  p_stat_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == OffFltStat |=> busRdata[23]);

  p_high_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && int'(busAddr) >= SpanWords |=> busRdata == '0);

  p_fault_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    faultLoad ##1 (busRdEn && busAddr == OffFltAddr && !faultLoad)
    |=> busRdata == $past(faultAddr, 2));
endmodule

bind iommu_regs iommu_regs_checker #(.VersionId(VersionId)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .busRdata   (busRdata),
  .faultLoad  (faultLoad),
  .faultAddr  (faultAddr),
  .windowStart(windowStart)
);

// File: tb/iommu_regs_bench.sv
module iommu_regs_bench;
  localparam logic [7:0] Ver = 8'h41;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0, faultLoad = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, faultStatus = '0, faultAddr = '0;
  logic [31:0] busRdata, windowStart;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #4 clk = ~clk;

  iommu_regs #(.VersionId(Ver)) u_iommu_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .faultLoad(faultLoad), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .windowStart(windowStart)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Monitor: read strobe seen at a rising edge, data compared at next falling edge
  always @(posedge clk) rdSeen <= rstN && busRdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual %08h expected <no pending read>", busRdata);
      end else begin
        check(tagQ.pop_front(), busRdata, expQ.pop_front());
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    busRdEn = 1'b1; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 window", windowStart, 32'h0);
    rd(12'h000, {Ver, 24'h0}, "R1 ctrl");
    rd(12'h800, 32'h8, "R1 arb");
    rd(12'h400, 32'h0080_0000, "R1 status");
    rd(12'h001, 32'h0, "R1 base");
    rd(12'h401, 32'h0, "R1 faddr");
    rd(12'h406, 32'h0, "R1 slot2");
    rd(12'h123, 32'h0, "R1 plain");
    // R2 control mask and version
    wr(12'h000, 32'hFFFF_FFFF);
    check("R3 window code7", windowStart, 32'h8000_0000);
    rd(12'h000, {Ver, 24'h1D}, "R2 ctrl all ones");
    wr(12'h000, 32'h0000_0062);
    rd(12'h000, {Ver, 24'h0}, "R2 ctrl unmasked bits");
    // R3 window decode for every code
    for (int c = 0; c < 8; c++) begin
      wr(12'h000, (32'(c) << 2) | 32'h1);
      check($sformatf("R3 window code%0d", c), windowStart,
            ~((32'h0100_0000 << c) - 32'h1));
    end
    wr(12'h001, 32'h0);
    check("R3 window unchanged by other write", windowStart, 32'h8000_0000);
    // R4
    wr(12'h001, 32'hFFFF_FFFF);
    wr(12'h005, 32'h1234_5678);
    wr(12'h006, 32'hDEAD_BEEF);
    rd(12'h001, 32'h07FF_FC00, "R4 base");
    rd(12'h005, 32'h1234_5678, "R4 flush all");
    rd(12'h006, 32'hDEAD_BEEF, "R4 flush page");
    // R5
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, 32'hFF8F_FFFF, "R5 status ones");
    wr(12'h400, 32'h0);
    rd(12'h400, 32'h0080_0000, "R5 status zero");
    wr(12'h401, 32'hCAFE_F00D);
    rd(12'h401, 32'hCAFE_F00D, "R5 faddr");
    // R6
    wr(12'h404, 32'hFFFF_FFFF);
    wr(12'h407, 32'h0000_0004);
    wr(12'h405, 32'h0001_0001);
    rd(12'h404, 32'h0001_0003, "R6 slot0");
    rd(12'h405, 32'h0001_0001, "R6 slot1");
    rd(12'h406, 32'h0, "R6 slot2 untouched");
    rd(12'h407, 32'h0, "R6 slot3");
    // R7
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h001F_0008, "R7 arb ones");
    wr(12'h800, 32'h0);
    rd(12'h800, 32'h8, "R7 arb zero");
    // R8 plain storage
    wr(12'h002, 32'h1357_9BDF);
    wr(12'h7FF, 32'hA5A5_5A5A);
    wr(12'hBFF, 32'hFFFF_FFFF);
    rd(12'h002, 32'h1357_9BDF, "R8 word2");
    rd(12'h7FF, 32'hA5A5_5A5A, "R8 word7FF");
    rd(12'hBFF, 32'hFFFF_FFFF, "R8 last word");
    // R9 beyond span
    wr(12'hC00, 32'hFFFF_FFFF);
    rd(12'hC00, 32'h0, "R9 word C00");
    rd(12'hFFF, 32'h0, "R9 word FFF");
    rd(12'h000, {Ver, 24'h1D}, "R9 no alias onto ctrl");
    // R10 fault load beats bus write
    faultLoad = 1'b1; faultStatus = 32'h1234_5678; faultAddr = 32'h8000_1000;
    busWrEn = 1'b1; busAddr = 12'h400; busWdata = 32'h0;
    @(negedge clk);
    faultLoad = 1'b0; busWrEn = 1'b0;
    rd(12'h400, 32'h1284_5678, "R10 status");
    rd(12'h401, 32'h8000_1000, "R10 addr");
    faultLoad = 1'b1; faultStatus = 32'h0; faultAddr = 32'h0BAD_0004;
    busWrEn = 1'b1; busAddr = 12'h401; busWdata = 32'h1111_1111;
    @(negedge clk);
    faultLoad = 1'b0; busWrEn = 1'b0;
    rd(12'h401, 32'h0BAD_0004, "R10 addr over write");
    rd(12'h400, 32'h0080_0000, "R10 status second");
    // R11 hold and repeat
    rd(12'h005, 32'h1234_5678, "R11 first read");
    rd(12'h005, 32'h1234_5678, "R11 repeat read");
    busAddr = 12'h006;
    repeat (3) @(negedge clk);
    check("R11 hold", busRdata, 32'h1234_5678);
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: actual %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule